// File: doc/BRIEF.md
# Early Branch Resolver With Delay Slot

This block sits in the decode stage and receives one instruction per cycle from fetch. Each instruction carries its tag: sequence number, PC, the branch target computed from the encoding, the target the front end predicted, a predicted-taken bit, control and direct-unconditional class bits, a conditional-delay-slot attribute, and its next and next-next PCs. Only direct unconditional branches are checked here. If the computed target differs from the predicted one, the block sends a redirect back to fetch. The redirect gives the correct target, a branch-taken flag and a survivor sequence number. Every instruction with a larger number is discarded.

The delay slot decides when the redirect fires. A mismatching branch that was predicted taken and whose delay slot is conditional is squashed at once, and the branch itself is the last survivor. Any other mismatching branch is forwarded first. The block then waits for the next accepted instruction, which is the delay slot, forwards it, and raises the redirect after it. A non-control instruction that the front end marked as taken also causes an immediate redirect. While a redirect is visible, the block drops younger incoming instructions. It also drives a kill mask over the sequence numbers of instructions still in flight in later stages.

Top module: `earlyBranchResolver`

## Requirements
- R1: An accepted instruction with inIsCtrl=1 and inDirUncond=1 that is not a pending delay slot counts as resolved. resolvedCount increases by one in the cycle after it is accepted. Other instructions, including a delay slot that is itself such a branch, leave the count unchanged.
- R2: A resolved branch whose computed target equals its predicted target raises no redirect. A control instruction that is not direct-unconditional raises no redirect whatever its targets are.
- R3: A resolved branch whose targets differ, with inPredTaken=1 and inCondSlot=1, raises redirSquash in the cycle after it is accepted. redirSurvivor then equals the branch's own sequence number.
- R4: Any other resolved branch whose targets differ raises no redirect by itself. The next accepted instruction, after any number of idle cycles, is forwarded as the delay slot and is not resolved. redirSquash rises in the cycle after that instruction, with redirSurvivor equal to the branch's sequence number plus one.
- R5: A redirect caused by a branch has redirBranchMispredict=1 and redirTarget equal to the branch's computed target. redirSquash is high only in the cycle after the event that caused it.
- R6: redirTaken is 1 when the causing instruction's next-next PC differs from its next PC plus 4, and 0 otherwise.
- R7: An incoming instruction whose sequence number is greater than redirSurvivor, while redirSquash is high, is not forwarded: fwdValid is 0 in the next cycle. Every other valid input appears on fwdValid, fwdSeq and fwdPc in the cycle after it arrives.
- R8: killMask bit i is 1 exactly when redirSquash=1, inflightValid bit i is 1, and inflightSeq entry i is greater than redirSurvivor. The comparison is a plain unsigned one at SEQ_W bits.
- R9: An accepted, non-delay-slot instruction with inPredTaken=1 and inIsCtrl=0 raises an immediate redirect. It has redirBranchMispredict=0, redirTarget equal to its PC plus 4, and redirSurvivor equal to its own sequence number.
- R10: A forwarded branch whose targets differ carries its computed target on fwdPredTarget. Every other forwarded instruction carries its predicted target unchanged.
- R11: After reset, fwdValid, redirSquash, killMask and resolvedCount are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Incoming instruction present |
| inSeq | input | SEQ_W | Incoming sequence number |
| inPc | input | ADDR_W | Incoming PC |
| inCompTarget | input | ADDR_W | Branch target computed from the encoding |
| inPredTarget | input | ADDR_W | Target predicted by the front end |
| inPredTaken | input | 1 | Front end predicted taken |
| inIsCtrl | input | 1 | Instruction is a control transfer |
| inDirUncond | input | 1 | Control transfer is direct and unconditional |
| inCondSlot | input | 1 | Delay slot is conditional |
| inNextPc | input | ADDR_W | Next PC of the instruction |
| inNextNextPc | input | ADDR_W | Next-next PC of the instruction |
| inflightValid | input | INFLIGHT | Valid bits of in-flight entries |
| inflightSeq | input | INFLIGHT*SEQ_W | Sequence numbers of in-flight entries |
| fwdValid | output | 1 | Instruction forwarded to rename |
| fwdSeq | output | SEQ_W | Forwarded sequence number |
| fwdPc | output | ADDR_W | Forwarded PC |
| fwdPredTarget | output | ADDR_W | Forwarded predicted target, corrected on mispredict |
| redirSquash | output | 1 | Redirect and squash to fetch |
| redirBranchMispredict | output | 1 | Redirect caused by a branch target mismatch |
| redirTarget | output | ADDR_W | Redirect PC |
| redirTaken | output | 1 | Branch-taken flag of the redirect |
| redirSurvivor | output | SEQ_W | Largest surviving sequence number |
| killMask | output | INFLIGHT | Kill strobes for younger in-flight entries |
| resolvedCount | output | CNT_W | Count of resolved branches |

## Verification
The bench runs each delay-slot path. It sends an immediately squashed branch with a conditional slot. It sends deferred branches, both predicted not taken and predicted taken without a conditional slot, with idle gaps before the slot. A design that picked the wrong path would either let the delay slot be killed or redirect one instruction early, and would show the wrong survivor number. The bench makes the delay slot a mismatching branch itself, which catches a design that resolves it a second time. It sends a younger instruction during each redirect cycle, which catches a design that still forwards it. It uses in-flight numbers around the top of the sequence range, which catches a signed or wrapped compare in the kill mask. A non-control instruction predicted taken checks the fall-through target and the cleared branch-mispredict flag.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

  typedef enum logic [1:0] {
    SEL_BRANCH = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_PEND   = 2'd2
  } redirSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      fwdLoad;
    logic      fixTarget;
    logic      redirLoad;
    redirSel_e redirSel;
    logic      pendLoad;
    logic      countInc;
  } ebrStrobe_t;

  // comparisons from datapath to control
  typedef struct packed {
    logic redirActive;
    logic inYounger;
    logic targetDiff;
  } ebrStatus_t;

endpackage

// File: rtl/ebrDatapath.sv
module ebrDatapath
  import ebr_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int INFLIGHT   = 4,
  parameter int CNT_W      = 8,
  parameter int INST_BYTES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ebrStrobe_t                       strobe,
  output ebrStatus_t                       status,
  input  logic [SEQ_W-1:0]                 inSeq,
  input  logic [ADDR_W-1:0]                inPc,
  input  logic [ADDR_W-1:0]                inCompTarget,
  input  logic [ADDR_W-1:0]                inPredTarget,
  input  logic [ADDR_W-1:0]                inNextPc,
  input  logic [ADDR_W-1:0]                inNextNextPc,
  input  logic [INFLIGHT-1:0]              inflightValid,
  input  logic [INFLIGHT-1:0][SEQ_W-1:0]   inflightSeq,
  output logic                             fwdValid,
  output logic [SEQ_W-1:0]                 fwdSeq,
  output logic [ADDR_W-1:0]                fwdPc,
  output logic [ADDR_W-1:0]                fwdPredTarget,
  output logic                             redirSquash,
  output logic                             redirBranchMispredict,
  output logic [ADDR_W-1:0]                redirTarget,
  output logic                             redirTaken,
  output logic [SEQ_W-1:0]                 redirSurvivor,
  output logic [INFLIGHT-1:0]              killMask,
  output logic [CNT_W-1:0]                 resolvedCount
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic              takenNow;
  logic [ADDR_W-1:0] pendTarget;
  logic              pendTaken;
  logic [SEQ_W-1:0]  pendSurvivor;

  assign takenNow           = inNextNextPc != (inNextPc + STEP);
  assign status.redirActive = redirSquash;
  assign status.inYounger   = inSeq > redirSurvivor;
  assign status.targetDiff  = inCompTarget != inPredTarget;

  // forward register toward rename
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid      <= 1'b0;
      fwdSeq        <= '0;
      fwdPc         <= '0;
      fwdPredTarget <= '0;
    end else begin
      fwdValid <= strobe.fwdLoad;
      if (strobe.fwdLoad) begin
        fwdSeq        <= inSeq;
        fwdPc         <= inPc;
        fwdPredTarget <= strobe.fixTarget ? inCompTarget : inPredTarget;
      end
    end
  end

  // deferred redirect held until the delay slot passes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTarget   <= '0;
      pendTaken    <= 1'b0;
      pendSurvivor <= '0;
    end else if (strobe.pendLoad) begin
      pendTarget   <= inCompTarget;
      pendTaken    <= takenNow;
      pendSurvivor <= inSeq + SEQ_W'(1);
    end
  end

  // redirect register toward fetch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirSquash           <= 1'b0;
      redirBranchMispredict <= 1'b0;
      redirTarget           <= '0;
      redirTaken            <= 1'b0;
      redirSurvivor         <= '0;
    end else begin
      redirSquash <= strobe.redirLoad;
      if (strobe.redirLoad) begin
        unique case (strobe.redirSel)
          SEL_CTRL: begin
            redirBranchMispredict <= 1'b0;
            redirTarget           <= inPc + STEP;
            redirTaken            <= takenNow;
            redirSurvivor         <= inSeq;
          end
          SEL_PEND: begin
            redirBranchMispredict <= 1'b1;
            redirTarget           <= pendTarget;
            redirTaken            <= pendTaken;
            redirSurvivor         <= pendSurvivor;
          end
          default: begin
            redirBranchMispredict <= 1'b1;
            redirTarget           <= inCompTarget;
            redirTaken            <= takenNow;
            redirSurvivor         <= inSeq;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                resolvedCount <= '0;
    else if (strobe.countInc) resolvedCount <= resolvedCount + CNT_W'(1);
  end

  // kill comparator bank
  for (genvar g = 0; g < INFLIGHT; g++) begin : genKill
    assign killMask[g] = redirSquash && inflightValid[g] &&
                         (inflightSeq[g] > redirSurvivor);
  end

endmodule

// File: rtl/ebrControl.sv
module ebrControl
  import ebr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inPredTaken,
  input  logic       inIsCtrl,
  input  logic       inDirUncond,
  input  logic       inCondSlot,
  input  ebrStatus_t status,
  output ebrStrobe_t strobe
);

  logic pending;
  logic drop, accept, slot, fresh, ctrlMis, resolve, mis, early, defer;

  always_comb begin
    drop    = inValid && status.redirActive && status.inYounger;
    accept  = inValid && !drop;
    slot    = accept && pending;
    fresh   = accept && !pending;
    ctrlMis = fresh && inPredTaken && !inIsCtrl;
    resolve = fresh && inIsCtrl && inDirUncond;
    mis     = resolve && status.targetDiff;
    early   = mis && inPredTaken && inCondSlot;
    defer   = mis && !(inPredTaken && inCondSlot);

    strobe.fwdLoad   = accept;
    strobe.fixTarget = mis;
    strobe.redirLoad = early || ctrlMis || slot;
    strobe.redirSel  = slot ? SEL_PEND : (ctrlMis ? SEL_CTRL : SEL_BRANCH);
    strobe.pendLoad  = defer;
    strobe.countInc  = resolve;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      pending <= 1'b0;
    else if (defer) pending <= 1'b1;
    else if (slot)  pending <= 1'b0;
  end

endmodule

// File: rtl/earlyBranchResolver.sv
module earlyBranchResolver
  import ebr_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int INFLIGHT   = 4,
  parameter int CNT_W      = 8,
  parameter int INST_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [SEQ_W-1:0]               inSeq,
  input  logic [ADDR_W-1:0]              inPc,
  input  logic [ADDR_W-1:0]              inCompTarget,
  input  logic [ADDR_W-1:0]              inPredTarget,
  input  logic                           inPredTaken,
  input  logic                           inIsCtrl,
  input  logic                           inDirUncond,
  input  logic                           inCondSlot,
  input  logic [ADDR_W-1:0]              inNextPc,
  input  logic [ADDR_W-1:0]              inNextNextPc,
  input  logic [INFLIGHT-1:0]            inflightValid,
  input  logic [INFLIGHT-1:0][SEQ_W-1:0] inflightSeq,
  output logic                           fwdValid,
  output logic [SEQ_W-1:0]               fwdSeq,
  output logic [ADDR_W-1:0]              fwdPc,
  output logic [ADDR_W-1:0]              fwdPredTarget,
  output logic                           redirSquash,
  output logic                           redirBranchMispredict,
  output logic [ADDR_W-1:0]              redirTarget,
  output logic                           redirTaken,
  output logic [SEQ_W-1:0]               redirSurvivor,
  output logic [INFLIGHT-1:0]            killMask,
  output logic [CNT_W-1:0]               resolvedCount
);

  ebrStrobe_t strobe;
  ebrStatus_t status;

  ebrControl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPredTaken(inPredTaken),
    .inIsCtrl(inIsCtrl), .inDirUncond(inDirUncond), .inCondSlot(inCondSlot),
    .status(status), .strobe(strobe)
  );

  ebrDatapath #(
    .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .INFLIGHT(INFLIGHT),
    .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .inSeq(inSeq), .inPc(inPc), .inCompTarget(inCompTarget),
    .inPredTarget(inPredTarget), .inNextPc(inNextPc),
    .inNextNextPc(inNextNextPc), .inflightValid(inflightValid),
    .inflightSeq(inflightSeq), .fwdValid(fwdValid), .fwdSeq(fwdSeq),
    .fwdPc(fwdPc), .fwdPredTarget(fwdPredTarget), .redirSquash(redirSquash),
    .redirBranchMispredict(redirBranchMispredict), .redirTarget(redirTarget),
    .redirTaken(redirTaken), .redirSurvivor(redirSurvivor),
    .killMask(killMask), .resolvedCount(resolvedCount)
  );

endmodule

// File: rtl/ebrChecker.sv
module ebrChecker #(
  parameter int SEQ_W    = 16,
  parameter int INFLIGHT = 4,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [SEQ_W-1:0]    inSeq,
  input logic [INFLIGHT-1:0] inflightValid,
  input logic                fwdValid,
  input logic [SEQ_W-1:0]    fwdSeq,
  input logic                redirSquash,
  input logic                redirBranchMispredict,
  input logic [SEQ_W-1:0]    redirSurvivor,
  input logic [INFLIGHT-1:0] killMask,
  input logic [CNT_W-1:0]    resolvedCount
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (resolvedCount == $past(resolvedCount)) ||
    (resolvedCount == $past(resolvedCount) + CNT_W'(1)));

  assert_redirect_forwards_R5: assert property (@(posedge clk) disable iff (!rstN)
    redirSquash |-> fwdValid);

  assert_drop_younger_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && redirSquash && (inSeq > redirSurvivor)) |=> !fwdValid);

  assert_kill_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !redirSquash |-> (killMask == '0));

  assert_kill_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (killMask & ~inflightValid) == '0);

  assert_ctrl_survivor_R9: assert property (@(posedge clk) disable iff (!rstN)
    (redirSquash && !redirBranchMispredict) |-> (fwdValid && fwdSeq == redirSurvivor));

endmodule

bind earlyBranchResolver ebrChecker #(
  .SEQ_W(SEQ_W), .INFLIGHT(INFLIGHT), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq),
  .inflightValid(inflightValid), .fwdValid(fwdValid), .fwdSeq(fwdSeq),
  .redirSquash(redirSquash), .redirBranchMispredict(redirBranchMispredict),
  .redirSurvivor(redirSurvivor), .killMask(killMask),
  .resolvedCount(resolvedCount)
);

// File: tb/earlyBranchResolver_tb.sv
module earlyBranchResolver_tb_top;

  localparam int SW = 16;
  localparam int AW = 32;
  localparam int NF = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          inValid = 0, inPredTaken = 0, inIsCtrl = 0, inDirUncond = 0, inCondSlot = 0;
  logic [SW-1:0] inSeq = 0;
  logic [AW-1:0] inPc = 0, inCompTarget = 0, inPredTarget = 0, inNextPc = 0, inNextNextPc = 0;
  logic [NF-1:0] inflightValid = 0;
  logic [NF-1:0][SW-1:0] inflightSeq = '0;

  logic          fwdValid, redirSquash, redirBranchMispredict, redirTaken;
  logic [SW-1:0] fwdSeq, redirSurvivor;
  logic [AW-1:0] fwdPc, fwdPredTarget, redirTarget;
  logic [NF-1:0] killMask;
  logic [CW-1:0] resolvedCount;

  earlyBranchResolver #(.SEQ_W(SW), .ADDR_W(AW), .INFLIGHT(NF), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSeq(inSeq), .inPc(inPc),
    .inCompTarget(inCompTarget), .inPredTarget(inPredTarget),
    .inPredTaken(inPredTaken), .inIsCtrl(inIsCtrl), .inDirUncond(inDirUncond),
    .inCondSlot(inCondSlot), .inNextPc(inNextPc), .inNextNextPc(inNextNextPc),
    .inflightValid(inflightValid), .inflightSeq(inflightSeq),
    .fwdValid(fwdValid), .fwdSeq(fwdSeq), .fwdPc(fwdPc),
    .fwdPredTarget(fwdPredTarget), .redirSquash(redirSquash),
    .redirBranchMispredict(redirBranchMispredict), .redirTarget(redirTarget),
    .redirTaken(redirTaken), .redirSurvivor(redirSurvivor),
    .killMask(killMask), .resolvedCount(resolvedCount)
  );

  int checks = 0;
  int errors = 0;

  // reference state: what the outputs must show after the next edge
  logic          eFv = 0, eSq = 0, eBm = 0, eTk = 0;
  logic [SW-1:0] eFs = 0, eSurv = 0;
  logic [AW-1:0] eFp = 0, eFt = 0, eTgt = 0;
  int            eCnt = 0;
  bit            waitSlot = 0;
  logic [AW-1:0] holdTgt;
  logic          holdTk;
  logic [SW-1:0] holdSurv;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareOutputs();
    chk("R7 fwdValid", 64'(fwdValid), 64'(eFv));
    if (eFv) begin
      chk("R7 fwdSeq", 64'(fwdSeq), 64'(eFs));
      chk("R7 fwdPc", 64'(fwdPc), 64'(eFp));
      chk("R10 fwdPredTarget", 64'(fwdPredTarget), 64'(eFt));
    end
    chk("R2 R3 R4 R5 redirSquash", 64'(redirSquash), 64'(eSq));
    if (eSq) begin
      chk("R9 redirBranchMispredict", 64'(redirBranchMispredict), 64'(eBm));
      chk("R5 redirTarget", 64'(redirTarget), 64'(eTgt));
      chk("R6 redirTaken", 64'(redirTaken), 64'(eTk));
      chk("R3 R4 redirSurvivor", 64'(redirSurvivor), 64'(eSurv));
    end
    chk("R1 resolvedCount", 64'(resolvedCount), 64'(eCnt[CW-1:0]));
  endtask

  task automatic compareKill();
    logic [NF-1:0] k;
    for (int i = 0; i < NF; i++)
      k[i] = eSq && inflightValid[i] && (inflightSeq[i] > eSurv);
    chk("R8 killMask", 64'(killMask), 64'(k));
  endtask

  // one cycle: check what is on the outputs, apply new inputs, predict
  task automatic step(bit v, int seq, int pc, int comp, int pred,
                      bit pt, bit ctl, bit du, bit cds, int nnpc);
    bit dropIt, take, asSlot, fresh, badCtl, isRes, wrong, tk;
    @(negedge clk);
    compareOutputs();
    inValid = v; inSeq = SW'(seq); inPc = AW'(pc); inCompTarget = AW'(comp);
    inPredTarget = AW'(pred); inPredTaken = pt; inIsCtrl = ctl;
    inDirUncond = du; inCondSlot = cds; inNextPc = AW'(pc + 4);
    inNextNextPc = AW'(nnpc);
    #1;
    compareKill();
    dropIt = v && eSq && (SW'(seq) > eSurv);
    take   = v && !dropIt;
    asSlot = take && waitSlot;
    fresh  = take && !waitSlot;
    badCtl = fresh && pt && !ctl;
    isRes  = fresh && ctl && du;
    wrong  = isRes && (comp != pred);
    tk     = AW'(nnpc) != AW'(pc + 8);
    eFv = take;
    if (take) begin
      eFs = SW'(seq); eFp = AW'(pc); eFt = wrong ? AW'(comp) : AW'(pred);
    end
    eSq = 0;
    if (badCtl) begin
      eSq = 1; eBm = 0; eTgt = AW'(pc + 4); eTk = tk; eSurv = SW'(seq);
    end else if (wrong && pt && cds) begin
      eSq = 1; eBm = 1; eTgt = AW'(comp); eTk = tk; eSurv = SW'(seq);
    end else if (asSlot) begin
      eSq = 1; eBm = 1; eTgt = holdTgt; eTk = holdTk; eSurv = holdSurv;
      waitSlot = 0;
    end
    if (wrong && !(pt && cds)) begin
      waitSlot = 1; holdTgt = AW'(comp); holdTk = tk; holdSurv = SW'(seq + 1);
    end
    if (isRes) eCnt++;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic plain(int seq, int pc);
    step(1, seq, pc, 0, 0, 0, 0, 0, 0, pc + 8);
  endtask
  task automatic jump(int seq, int pc, int comp, int pred, bit pt, bit cds, int nnpc);
    step(1, seq, pc, comp, pred, pt, 1, 1, cds, nnpc);
  endtask
  task automatic setFlight(int a, int b, int c, int d);
    inflightValid = '1;
    inflightSeq[0] = SW'(a); inflightSeq[1] = SW'(b);
    inflightSeq[2] = SW'(c); inflightSeq[3] = SW'(d);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 fwdValid", 64'(fwdValid), 0);
    chk("R11 redirSquash", 64'(redirSquash), 0);
    chk("R11 killMask", 64'(killMask), 0);
    chk("R11 resolvedCount", 64'(resolvedCount), 0);

    // R2: correctly predicted direct branch, plain instructions
    plain(1, 'h100);
    jump(2, 'h104, 'h200, 'h200, 1, 0, 'h200);
    plain(3, 'h200);
    // R2: indirect control with differing targets is not resolved
    step(1, 4, 'h204, 'h300, 'h340, 1, 1, 0, 0, 'h340);
    idle();

    // R3: immediate squash, younger incoming dropped (R7), kill (R8)
    jump(10, 'h300, 'h400, 'h380, 1, 1, 'h380);
    setFlight(9, 11, 12, 13);
    plain(11, 'h384);
    inflightValid = '0;
    plain(12, 'h400);
    idle();

    // R4: deferred, predicted not taken, slot after a gap, slot is itself a branch
    jump(20, 'h500, 'h600, 'h540, 0, 0, 'h508);
    idle();
    idle();
    jump(21, 'h504, 'h700, 'h800, 1, 1, 'h800);
    setFlight(20, 21, 22, 23);
    plain(22, 'h508);
    inflightValid = '0;
    idle();

    // R4: deferred, predicted taken without conditional slot; older accepted in redirect cycle
    jump(30, 'h900, 'hA00, 'h980, 1, 0, 'hA00);
    plain(31, 'h904);
    plain(30, 'h908);
    plain(32, 'hA00);
    idle();

    // R9: non-control predicted taken
    step(1, 40, 'hB00, 0, 'hC00, 1, 0, 0, 0, 'hB08);
    plain(41, 'hB04);
    plain(42, 'hB04);
    idle();

    // R8: unsigned compare near the top of the range
    jump('hFFF0, 'hD00, 'hE00, 'hD80, 1, 1, 'hD80);
    setFlight('h0002, 'hFFF1, 'hFFEF, 'hFFF0);
    idle();
    inflightValid = '0;
    idle();

    // R6: taken flag clear when next-next equals next plus 4
    jump(50, 'hF00, 'hF40, 'hF80, 1, 1, 'hF08);
    idle();
    idle();
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule